// File: doc/BRIEF.md
# Error Interrupt Status and Mask Registers

This block is a small memory-mapped register group for one error-interrupt source: an address-decode error that other logic detects and reports with a one-cycle pulse. Software sees five 32-bit words. The first is a control word holding a slave-error enable bit. The second is a status word that the hardware pulse sets and software clears by writing ones. The third is a read-only mask word. The fourth and fifth are command words: writing ones to them clears or sets mask bits.

The block drives one level-sensitive interrupt output. It is high while a status bit is pending and that bit's mask is clear. The mask starts set, so the interrupt is silent until software enables it. The bus side is a plain word-access register port. It has a write enable, a read strobe, a byte address and write data. Read data is registered. The number of interrupt bits is a parameter and defaults to one.

Top module: `err_irq_regs`

## Requirements
- R1: After reset, the status bits are 0, every mask bit is 1, the slave-error enable is 0 and `irq_o` is low. Reading the mask word at offset 0x8 returns the value 0x1.
- R2: When `err_set_i[i]` is high for one cycle, status bit i (offset 0x4, bit i) is 1 from the next clock edge. It stays 1 until software clears it.
- R3: Writing to the status word at offset 0x4 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: If a hardware set and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up 1.
- R5: The mask word at offset 0x8 is read-only. A write to it leaves the mask unchanged.
- R6: Writing to the enable command at offset 0xC clears every mask bit whose write-data bit is 1. Other mask bits keep their value.
- R7: Writing to the disable command at offset 0x10 sets every mask bit whose write-data bit is 1. Other mask bits keep their value.
- R8: The enable and disable command words always read as 0.
- R9: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. It reflects the register state from the clock edge that follows the write or set pulse that changed it.
- R10: Control bit 0 at offset 0x0 is a read/write slave-error enable. It reads back at offset 0x0, bit 0, and drives `slverr_en_o`.
- R11: `rdata` carries the addressed word one clock edge after a cycle with `rd_en` high. At that edge it shows the state from before any write in the same cycle. After a cycle without `rd_en`, `rdata` is 0.
- R12: These accesses read as 0 and are ignored on write: any offset other than the five listed, and any byte address whose two low bits are not zero. Undefined bits of the defined words also read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| rd_en | input | 1 | Read strobe; the data appears on `rdata` one cycle later |
| addr | input | ADDR_W (8) | Byte address of the access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| err_set_i | input | NUM_SRC (1) | One-cycle pulses that set status bits |
| slverr_en_o | output | 1 | Slave-error enable from the control word |
| irq_o | output | 1 | Level interrupt: pending and unmasked |

## Verification
The bench drives a hardware set pulse and a clear write to the same bit in the same cycle. A design that gave priority to the clear would lose the error event. It writes to the read-only mask word after unmasking and checks that the interrupt stays enabled. A design that allowed a direct mask write would silence the interrupt. It also writes the command words and reads them back expecting zero, which catches a design that stored the command data. It sends misaligned and unmapped addresses, which catches an address decode that ignores the low bits. Random traffic, mixed with set pulses, checks the interrupt level against the pending and unmasked condition on every cycle.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
    localparam int unsigned OFF_CTL  = 32'h00;
    localparam int unsigned OFF_STAT = 32'h04;
    localparam int unsigned OFF_MASK = 32'h08;
    localparam int unsigned OFF_EN   = 32'h0C;
    localparam int unsigned OFF_DIS  = 32'h10;

    typedef struct packed {
        logic ctl;
        logic stat;
        logic mask;
        logic en;
        logic dis;
    } reg_sel_t;
endpackage

// File: rtl/err_irq_addr_dec.sv
module err_irq_addr_dec
    import err_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    // Full-width comparison: a misaligned byte address never matches a word.
    always_comb begin
        sel      = '0;
        sel.ctl  = (addr == ADDR_W'(OFF_CTL));
        sel.stat = (addr == ADDR_W'(OFF_STAT));
        sel.mask = (addr == ADDR_W'(OFF_MASK));
        sel.en   = (addr == ADDR_W'(OFF_EN));
        sel.dis  = (addr == ADDR_W'(OFF_DIS));
    end
endmodule

// File: rtl/err_irq_state.sv
module err_irq_state
    import err_irq_pkg::*;
#(
    parameter int NUM_SRC = 1,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_sel_t           sel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] set_i,
    output logic [NUM_SRC-1:0] stat_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               slverr_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] stat;
        logic [NUM_SRC-1:0] mask;
        logic               slverr;
    } state_t;

    state_t s_d, s_q;
    logic [NUM_SRC-1:0] wbits;

    assign wbits = wdata[NUM_SRC-1:0];

    always_comb begin
        s_d = s_q;
        if (wr_en && sel.stat) s_d.stat = s_q.stat & ~wbits;
        // Hardware set is applied after the clear so that it wins.
        s_d.stat = s_d.stat | set_i;
        if (wr_en && sel.en)   s_d.mask = s_q.mask & ~wbits;
        if (wr_en && sel.dis)  s_d.mask = s_q.mask | wbits;
        if (wr_en && sel.ctl)  s_d.slverr = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stat   <= '0;
            s_q.mask   <= '1;
            s_q.slverr <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stat_o   = s_q.stat;
    assign mask_o   = s_q.mask;
    assign slverr_o = s_q.slverr;

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.stat && set_i == '0) |=> ((stat_o & $past(wbits)) == '0));

    assert_mask_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.mask) |=> $stable(mask_o));

    assert_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.en) |=> ((mask_o & $past(wbits)) == '0));

    assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.dis) |=> ((mask_o & $past(wbits)) == $past(wbits)));

    assert_ctl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.ctl) |=> (slverr_o == $past(wdata[0])));
endmodule

// File: rtl/err_irq_rd_mux.sv
module err_irq_rd_mux
    import err_irq_pkg::*;
#(
    parameter int NUM_SRC = 1,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  reg_sel_t           sel,
    input  logic [NUM_SRC-1:0] stat,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               slverr,
    output logic [DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        word = '0;
        if (sel.ctl)  word = DATA_W'(slverr);
        if (sel.stat) word = DATA_W'(stat);
        if (sel.mask) word = DATA_W'(mask);
        rdata_d = rd_en ? word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel.en || sel.dis)) |=> (rdata == '0));
endmodule

// File: rtl/err_irq_regs.sv
module err_irq_regs
    import err_irq_pkg::*;
#(
    parameter int NUM_SRC = 1,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_SRC-1:0] err_set_i,
    output logic               slverr_en_o,
    output logic               irq_o
);
    reg_sel_t           sel;
    logic [NUM_SRC-1:0] stat, mask;

    err_irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    err_irq_state #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (wdata),
        .set_i    (err_set_i),
        .stat_o   (stat),
        .mask_o   (mask),
        .slverr_o (slverr_en_o)
    );

    err_irq_rd_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .sel    (sel),
        .stat   (stat),
        .mask   (mask),
        .slverr (slverr_en_o),
        .rdata  (rdata)
    );

    assign irq_o = |(stat & ~mask);

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_o);

    assert_pending_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set_i && ((err_set_i & ~mask) == err_set_i) && !(wr_en && (sel.dis || sel.en)))
        |=> irq_o);
endmodule

// File: tb/sim_err_irq_regs.sv
`timescale 1ns/1ps
module sim_err_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [0:0]  err_set = '0;
    logic        slverr_en, irq;

    int checks = 0;
    int errors = 0;

    logic m_stat, m_mask, m_ctl;

    always #2.5 clk = ~clk;

    err_irq_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err_set_i(err_set),
        .slverr_en_o(slverr_en), .irq_o(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return {31'b0, m_ctl};
            8'h04: return {31'b0, m_stat};
            8'h08: return {31'b0, m_mask};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_req(input logic [7:0] a);
        case (a)
            8'h00: return "R10";
            8'h04: return "R2";
            8'h08: return "R5";
            8'h0C, 8'h10: return "R8";
            default: return "R12";
        endcase
    endfunction

    // One bus cycle, entered and left at a falling edge.
    task automatic step(input logic we, input logic re, input logic [7:0] a,
                        input logic [31:0] d, input logic s, input string tag);
        logic [31:0] rexp;
        wr_en = we; rd_en = re; addr = a; wdata = d; err_set = s;
        rexp = exp_read(a);
        if (we && a == 8'h04 && d[0]) m_stat = 1'b0;
        if (s) m_stat = 1'b1;
        if (we && a == 8'h0C && d[0]) m_mask = 1'b0;
        if (we && a == 8'h10 && d[0]) m_mask = 1'b1;
        if (we && a == 8'h00) m_ctl = d[0];
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; err_set = 1'b0;
        check(irq === (m_stat & ~m_mask), {tag, " R9 irq"}, {31'b0, irq}, {31'b0, m_stat & ~m_mask});
        check(slverr_en === m_ctl, "R10 slverr_en", {31'b0, slverr_en}, {31'b0, m_ctl});
        if (re) check(rdata === rexp, {read_req(a), " read"}, rdata, rexp);
        else    check(rdata === 32'h0, "R11 idle rdata", rdata, 32'h0);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] addrs [8];
        void'($urandom(32'h5EED_0042));
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C, 8'h06};
        m_stat = 1'b0; m_mask = 1'b1; m_ctl = 1'b0;
        repeat (3) @(negedge clk);
        check(irq === 1'b0 && rdata === 32'h0, "R1 reset outputs", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values through reads
        step(0, 1, 8'h08, 0, 0, "R1");
        step(0, 1, 8'h04, 0, 0, "R1");
        step(0, 1, 8'h00, 0, 0, "R1");
        // R2/R9: set while masked keeps irq low
        step(0, 0, 8'h00, 0, 1, "R2");
        step(0, 1, 8'h04, 0, 0, "R2");
        // R6: enable unmasks, irq rises
        step(1, 0, 8'h0C, 32'hFFFF_FFFF, 0, "R6");
        step(0, 1, 8'h08, 0, 0, "R6");
        // R5: direct mask write ignored
        step(1, 0, 8'h08, 32'h1, 0, "R5");
        step(0, 1, 8'h08, 0, 0, "R5");
        // R3: writing zero keeps status
        step(1, 0, 8'h04, 32'h0, 0, "R3");
        step(0, 1, 8'h04, 0, 0, "R3");
        // R4: clear and set together, set wins
        step(1, 0, 8'h04, 32'h1, 1, "R4");
        step(0, 1, 8'h04, 0, 0, "R4");
        // R3: clear drops irq
        step(1, 0, 8'h04, 32'h1, 0, "R3");
        // R11: read sees state before simultaneous write
        step(1, 1, 8'h00, 32'h1, 0, "R11");
        step(0, 1, 8'h00, 0, 0, "R10");
        // R8: command words read zero
        step(0, 1, 8'h0C, 0, 0, "R8");
        step(0, 1, 8'h10, 0, 0, "R8");
        // R12: misaligned and unmapped writes ignored
        step(1, 0, 8'h01, 32'h0, 0, "R12");
        step(1, 0, 8'h0D, 32'h1, 0, "R12");
        step(1, 0, 8'h14, 32'h1, 0, "R12");
        step(0, 1, 8'h00, 0, 0, "R12");
        step(0, 1, 8'h1C, 0, 0, "R12");
        // R7: disable masks a pending bit
        step(0, 0, 8'h00, 0, 1, "R7");
        step(1, 0, 8'h10, 32'h1, 0, "R7");
        step(0, 1, 8'h08, 0, 0, "R7");
        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            a = addrs[$urandom_range(0, 7)];
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom(),
                 ($urandom_range(0, 3) == 0), "RND");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule